// File: doc/BRIEF.md
# Divided Countdown Interrupt Timer

This block is a countdown timer with an interrupt output. It runs on the core clock. A programmable power-of-two prescaler slows the clock down to a tick rate. Three register-style write ports load the prescaler setting, the start value and a control word. The control word carries an 8-bit interrupt vector, a suppress bit and a repeat-mode bit.

The current count can be read at all times. When the count reaches zero, the block raises a one-cycle interrupt pulse that carries the vector. In repeat mode the count then reloads the start value on the following tick. In single-shot mode it stays at zero.

The interrupt pulse is a plain event strobe and has no back-pressure. No ready signal exists. A receiver that cannot take the pulse in the cycle it is high loses it. The write ports are also plain strobes, and each takes effect at the clock edge where it is sampled. Writing a start value of zero parks the timer.

Top module: `cdt_timer`

## Requirements
- R1: After reset, `cur_count` is 0, `irq_valid` is 0, `div_cfg` is 0 and `ctrl_word` reads 0x10000 (suppressed, single-shot, vector 0).
- R2: A divide-setting write stores only bits 3, 1 and 0 of `div_wdata`. Bit 2 always reads back as 0. A control write stores only bits 17, 16 and 7:0 of `ctrl_wdata`.
- R3: The prescaler code is {bit 3, bit 1, bit 0} of the stored divide setting, and the tick period is 2^((code+1) mod 8) clocks. Code 7 gives 1 clock, code 0 gives 2 clocks and code 6 gives 128 clocks.
- R4: A start-value write loads `cur_count` with the written value at that clock edge and restarts the prescaler from zero. The first decrement then happens exactly one full tick period after the write edge.
- R5: In single-shot mode (control bit 17 = 0), each tick lowers the count by one until it reaches 0. After that the count holds at 0 and no further interrupt is raised.
- R6: In repeat mode (control bit 17 = 1), a tick at count 0 reloads the stored start value, so one cycle lasts start value + 1 ticks.
- R7: When a tick moves the count from 1 to 0 and control bit 16 is clear, `irq_valid` is high for exactly one cycle. That cycle is the first one in which `cur_count` reads 0, and `irq_vector` then equals control bits 7:0.
- R8: When control bit 16 is set, a count reaching 0 raises no pulse, but repeat mode still reloads.
- R9: A start value of 0 stops the timer. The count stays at 0 and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_we | input | 1 | Divide-setting write strobe |
| div_wdata | input | 4 | Divide-setting write data |
| ctrl_we | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 18 | Control word: vector 7:0, suppress 16, repeat 17 |
| init_we | input | 1 | Start-value write strobe (restarts counting) |
| init_wdata | input | 32 | Start value |
| div_cfg | output | 4 | Stored divide setting |
| ctrl_word | output | 18 | Stored control word |
| cur_count | output | 32 | Current count (read-only) |
| irq_valid | output | 1 | One-cycle expiry pulse |
| irq_vector | output | 8 | Vector accompanying the pulse |

## Verification
The stimulus table runs many short scenarios. Each one combines a prescaler code, a start value, a mode and a suppress setting, and after a known number of clocks the bench compares the count and the number of pulses seen.

- Codes 7, 0, 1, 3, 4 and 6 are all used, so a wrong bit-to-code mapping or a shift that is off by one shows up as a wrong count.
- Single-shot and repeat runs that cover several periods separate clamping from reloading.
- Suppressed runs and a zero start value separate "reload without pulse" from "stopped".
- Directed sequences check a pulse cycle by cycle with its vector.
- Further directed sequences check a restart in the middle of a count, including the prescaler phase reset.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int SHIFT_W = 3;
  localparam int PRE_W   = (1 << SHIFT_W) - 1;
  localparam int CTRL_W  = 18;
  localparam int VEC_W   = 8;
  localparam int MASK_BIT = 16;
  localparam int REP_BIT  = 17;
  localparam logic [3:0]        DIV_KEEP  = 4'hB;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 18'h300FF;
  localparam logic [CTRL_W-1:0] CTRL_RST  = 18'h10000;

  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [2:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/cdt_prescaler.sv
module cdt_prescaler
  import cdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] sel_mask;

  assign sel_mask = ~({PRE_W{1'b1}} << shift);
  assign tick     = ((pre_q & sel_mask) == sel_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pre_q <= '0;
    else if (restart) pre_q <= '0;
    else              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/cdt_downcount.sv
module cdt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             repeat_mode,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] start_q,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  assign running = (start_q != '0);
  assign expire  = !restart && tick && running && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      start_q <= '0;
    end else if (restart) begin
      count   <= load_val;
      start_q <= load_val;
    end else if (tick && running) begin
      if (count != '0)      count <= count - ONE;
      else if (repeat_mode) count <= start_q;
    end
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_we,
  input  logic [3:0]        div_wdata,
  input  logic              ctrl_we,
  input  logic [17:0]       ctrl_wdata,
  input  logic              init_we,
  input  logic [CNT_W-1:0]  init_wdata,
  output logic [3:0]        div_cfg,
  output logic [17:0]       ctrl_word,
  output logic [CNT_W-1:0]  cur_count,
  output logic              irq_valid,
  output logic [7:0]        irq_vector
);
  logic [3:0]        div_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [SHIFT_W-1:0] shift;
  logic              tick;
  logic              expire;
  logic [CNT_W-1:0]  init_q;
  logic              ctrl_masked;
  logic              ctrl_periodic;

  assign ctrl_masked   = ctrl_q[MASK_BIT];
  assign ctrl_periodic = ctrl_q[REP_BIT];
  assign shift         = code_to_shift({div_q[3], div_q[1:0]});
  assign div_cfg       = div_q;
  assign ctrl_word     = ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      ctrl_q <= CTRL_RST;
    end else begin
      if (div_we)  div_q  <= div_wdata & DIV_KEEP;
      if (ctrl_we) ctrl_q <= ctrl_wdata & CTRL_KEEP;
    end
  end

  cdt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (init_we),
    .shift   (shift),
    .tick    (tick)
  );

  cdt_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .restart     (init_we),
    .load_val    (init_wdata),
    .tick        (tick),
    .repeat_mode (ctrl_periodic),
    .count       (cur_count),
    .start_q     (init_q),
    .expire      (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid <= expire && !ctrl_masked;
      if (expire) irq_vector <= ctrl_q[VEC_W-1:0];
    end
  end
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             init_we,
  input logic [CNT_W-1:0] init_wdata,
  input logic [CNT_W-1:0] cur_count,
  input logic [CNT_W-1:0] init_q,
  input logic             irq_valid,
  input logic             periodic,
  input logic             masked
);
  a_r4_restart_load: assert property (@(posedge clk) disable iff (!rst_n)
    init_we |=> cur_count == $past(init_wdata));

  a_r5_step_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(init_we) |-> (cur_count == $past(cur_count)) ||
                        (cur_count == $past(cur_count) - 1) ||
                        ($past(periodic) && $past(cur_count) == '0 && cur_count == $past(init_q)));

  a_r5_oneshot_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(init_we) && !$past(periodic) && $past(cur_count) == '0) |-> cur_count == '0);

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |=> !irq_valid);

  a_r7_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> cur_count == '0);

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !$past(masked));

  a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(init_q) != '0);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_we    (init_we),
  .init_wdata (init_wdata),
  .cur_count  (cur_count),
  .init_q     (init_q),
  .irq_valid  (irq_valid),
  .periodic   (ctrl_periodic),
  .masked     (ctrl_masked)
);

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        div_we = 1'b0;
  logic [3:0]  div_wdata = '0;
  logic        ctrl_we = 1'b0;
  logic [17:0] ctrl_wdata = '0;
  logic        init_we = 1'b0;
  logic [31:0] init_wdata = '0;
  logic [3:0]  div_cfg;
  logic [17:0] ctrl_word;
  logic [31:0] cur_count;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cdt_timer dut_i (
    .clk(clk), .rst_n(rst_n),
    .div_we(div_we), .div_wdata(div_wdata),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .init_we(init_we), .init_wdata(init_wdata),
    .div_cfg(div_cfg), .ctrl_word(ctrl_word), .cur_count(cur_count),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  typedef struct packed {
    logic [3:0]  cfg;
    logic [31:0] init;
    logic        per;
    logic        msk;
    logic [7:0]  vec;
    logic [15:0] wait_c;
    logic [31:0] exp_cnt;
    logic [15:0] exp_irq;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{4'hB, 32'd5, 1'b0, 1'b0, 8'h41, 16'd3,   32'd2, 16'd0},
    '{4'hB, 32'd5, 1'b0, 1'b0, 8'h42, 16'd10,  32'd0, 16'd1},
    '{4'h0, 32'd4, 1'b0, 1'b0, 8'h43, 16'd5,   32'd2, 16'd0},
    '{4'h0, 32'd3, 1'b0, 1'b0, 8'h44, 16'd20,  32'd0, 16'd1},
    '{4'h1, 32'd3, 1'b1, 1'b0, 8'h45, 16'd48,  32'd3, 16'd3},
    '{4'h8, 32'd2, 1'b1, 1'b0, 8'h46, 16'd100, 32'd2, 16'd1},
    '{4'h4, 32'd6, 1'b0, 1'b0, 8'h47, 16'd7,   32'd3, 16'd0},
    '{4'hB, 32'd2, 1'b1, 1'b1, 8'h48, 16'd9,   32'd2, 16'd0},
    '{4'hB, 32'd0, 1'b1, 1'b0, 8'h49, 16'd20,  32'd0, 16'd0},
    '{4'hA, 32'd1, 1'b0, 1'b0, 8'h4A, 16'd127, 32'd1, 16'd0},
    '{4'hA, 32'd1, 1'b0, 1'b0, 8'h4B, 16'd128, 32'd0, 16'd1},
    '{4'h3, 32'd1, 1'b1, 1'b0, 8'h4C, 16'd64,  32'd1, 16'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [3:0] v);
    div_wdata = v; div_we = 1'b1;
    @(posedge clk); @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_ctrl(input logic per, input logic msk, input logic [7:0] vec);
    ctrl_wdata = {per, msk, 8'h00, vec}; ctrl_we = 1'b1;
    @(posedge clk); @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic wr_init(input logic [31:0] v);
    init_wdata = v; init_we = 1'b1;
    @(posedge clk); @(negedge clk);
    init_we = 1'b0;
  endtask

  task automatic step(input int n, output int pulses);
    pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (irq_valid) pulses++;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 count", cur_count, 32'd0);
    check("R1 irq", {31'd0, irq_valid}, 32'd0);
    check("R1 div_cfg", {28'd0, div_cfg}, 32'd0);
    check("R1 ctrl", {14'd0, ctrl_word}, 32'h10000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field retention
    wr_div(4'hF);
    check("R2 div keep", {28'd0, div_cfg}, 32'hB);
    wr_div(4'h4);
    check("R2 div bit2", {28'd0, div_cfg}, 32'h0);
    ctrl_wdata = 18'h3FFFF; ctrl_we = 1'b1;
    @(posedge clk); @(negedge clk); ctrl_we = 1'b0;
    check("R2 ctrl keep", {14'd0, ctrl_word}, 32'h300FF);

    // Table: R3 R5 R6 R8 R9 across codes and modes
    for (int k = 0; k < NV; k++) begin
      wr_div(TBL[k].cfg);
      wr_ctrl(TBL[k].per, TBL[k].msk, TBL[k].vec);
      wr_init(TBL[k].init);
      step(int'(TBL[k].wait_c), p);
      check($sformatf("R3/R5/R6/R8/R9 row %0d count", k), cur_count, TBL[k].exp_cnt);
      check($sformatf("R7/R8/R9 row %0d pulses", k), p, {16'd0, TBL[k].exp_irq});
    end

    // R7 pulse timing and vector
    wr_div(4'hB);
    wr_ctrl(1'b0, 1'b0, 8'hA5);
    wr_init(32'd2);
    check("R4 load", cur_count, 32'd2);
    step(1, p);
    check("R7 pre count", cur_count, 32'd1);
    check("R7 pre irq", {31'd0, irq_valid}, 32'd0);
    step(1, p);
    check("R7 irq high", {31'd0, irq_valid}, 32'd1);
    check("R7 vector", {24'd0, irq_vector}, 32'hA5);
    check("R7 count zero", cur_count, 32'd0);
    step(1, p);
    check("R7 one cycle", {31'd0, irq_valid}, 32'd0);
    step(5, p);
    check("R5 held zero", cur_count, 32'd0);
    check("R5 no repeat pulse", p, 32'd0);

    // R4 restart in mid count
    wr_ctrl(1'b1, 1'b0, 8'h11);
    wr_init(32'd9);
    step(3, p);
    check("R4 running", cur_count, 32'd6);
    wr_init(32'd4);
    check("R4 reload", cur_count, 32'd4);
    step(1, p);
    check("R4 after reload", cur_count, 32'd3);

    // R4 prescaler phase reset (divide by 4)
    wr_div(4'h1);
    wr_init(32'd10);
    step(6, p);
    check("R4 phase a", cur_count, 32'd9);
    wr_init(32'd10);
    step(3, p);
    check("R4 phase hold", cur_count, 32'd10);
    step(1, p);
    check("R4 phase tick", cur_count, 32'd9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule